// File: doc/BRIEF.md
# Registered Four-Bit ALU with Range Flags

This block is a small arithmetic and logic core for a control datapath. On each rising clock edge it captures two data operands and a four-bit opcode. On the falling edge of the same clock it captures the result and two status flags, so a result is ready half a period after its operands are taken. The opcode is decoded into sixteen one-hot lines, and those lines steer a single shared adder and a set of bitwise and shift paths.

The flags do not follow the usual carry and overflow meaning. In this block they report range. The carry flag means the exact signed result was above the top of the four-bit two's complement range. The overflow flag means it was below the bottom of that range. When either flag is set, the result's top bit is corrected, so the top bit is always 0 in that case. Both flags are zero for every opcode that is not arithmetic.

Top module: `flag_alu`

## Requirements
- R1: A synchronous active-high reset clears the captured operands and opcode. It also clears the result and both flags to zero at the first falling edge it is seen at.
- R2: Operands and opcode are sampled only at the rising edge. The result and flags change only at the following falling edge. Input changes after the rising edge have no effect on the outputs that follow it.
- R3: Opcode 0 gives A, and opcode 3 gives B. Opcode 1 gives B rotated left by one, with bit 3 moving to bit 0. Opcode 10 gives A rotated right by one, with bit 0 moving to bit 3.
- R4: Opcode 9 gives A OR B, opcode 11 gives A AND B, and opcode 12 gives A XOR B, each bit by bit.
- R5: Opcode 13 gives the larger of A and B, compared as unsigned numbers.
- R6: The arithmetic opcodes are 2 (A-B), 4 (A+1), 5 (A-1), 6 (B+1), 7 (A+B), 8 (B-1), 14 (-B) and 15 (-A), all on signed values from -8 to +7. R[2:0] are the low three bits of the exact result. R[3] is bit 3 of the exact result XOR C.
- R7: For an arithmetic opcode, C is 1 exactly when the exact signed result is greater than +7. Examples are 0111+1, and the negation of 1000.
- R8: For an arithmetic opcode, V is 1 exactly when the exact signed result is less than -8. An example is 1000-1.
- R9: C and V are 0 for opcodes 0, 1, 3 and 9 to 13. C and V are never 1 together, and when either is 1, R[3] is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs captured on rise, outputs on fall |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | W (4) | Operand A |
| b_i | input | W (4) | Operand B |
| s_i | input | 4 | Opcode |
| r_o | output | W (4) | Registered result |
| c_o | output | 1 | Registered flag: result above signed range |
| v_o | output | 1 | Registered flag: result below signed range |

## Verification
There is no hidden state beyond one captured operand set. A wrong routing choice, flag term or decode line therefore shows up at the ports at the first falling edge after the affected opcode and operands are captured. Every opcode is swept against every operand pair, so each routing and flag term is exercised at its range edges. The bench also checks, just after each rising edge, that the outputs still hold the previous result. This catches an output register on the wrong edge half a period early.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int OP_W = 4;
    localparam int OP_N = 1 << OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_PASS_A = 4'h0,
        OP_ROL_B  = 4'h1,
        OP_SUB    = 4'h2,
        OP_PASS_B = 4'h3,
        OP_INC_A  = 4'h4,
        OP_DEC_A  = 4'h5,
        OP_INC_B  = 4'h6,
        OP_ADD    = 4'h7,
        OP_DEC_B  = 4'h8,
        OP_OR     = 4'h9,
        OP_ROR_A  = 4'hA,
        OP_AND    = 4'hB,
        OP_XOR    = 4'hC,
        OP_MAX    = 4'hD,
        OP_NEG_B  = 4'hE,
        OP_NEG_A  = 4'hF
    } op_e;

    // first adder leg source
    typedef enum logic [1:0] {
        X_OPER = 2'd0,
        X_ZERO = 2'd1,
        X_ONES = 2'd2
    } xsel_e;

    // swap: first leg takes B and second leg takes A
    typedef struct packed {
        logic  swap;
        xsel_e xsel;
        logic  yinv;
        logic  cin;
    } route_t;

    function automatic logic is_arith(input logic [OP_N-1:0] hot);
        return hot[OP_SUB] | hot[OP_INC_A] | hot[OP_DEC_A] | hot[OP_INC_B] |
               hot[OP_ADD] | hot[OP_DEC_B] | hot[OP_NEG_B] | hot[OP_NEG_A];
    endfunction

    function automatic route_t route_for(input logic [OP_N-1:0] hot);
        route_t rt;
        rt.swap = hot[OP_INC_A] | hot[OP_DEC_A] | hot[OP_NEG_A];
        rt.xsel = X_OPER;
        if (hot[OP_INC_A] | hot[OP_INC_B] | hot[OP_NEG_A] | hot[OP_NEG_B])
            rt.xsel = X_ZERO;
        if (hot[OP_DEC_A] | hot[OP_DEC_B])
            rt.xsel = X_ONES;
        rt.yinv = hot[OP_SUB] | hot[OP_NEG_A] | hot[OP_NEG_B];
        rt.cin  = rt.yinv | hot[OP_INC_A] | hot[OP_INC_B];
        return rt;
    endfunction

endpackage

// File: rtl/flag_alu_decode.sv
module flag_alu_decode
    import flag_alu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output logic [OP_N-1:0] hot
);
    for (genvar i = 0; i < OP_N; i++) begin : g_line
        assign hot[i] = (op == OP_W'(i));
    end
endmodule

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
    import flag_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  route_t       rt,
    input  logic         en,
    output logic [W-1:0] r,
    output logic         c,
    output logic         v
);
    localparam int MSB = W - 1;

    logic [W-1:0] p, q, x, y, sum;

    assign p = rt.swap ? b : a;
    assign q = rt.swap ? a : b;

    always_comb begin
        unique case (rt.xsel)
            X_ZERO:  x = '0;
            X_ONES:  x = '1;
            default: x = p;
        endcase
    end

    assign y   = rt.yinv ? ~q : q;
    assign sum = x + y + {{(W-1){1'b0}}, rt.cin};

    // both legs non-negative with negative sum: above range
    assign c = en & ~x[MSB] & ~y[MSB] &  sum[MSB];
    // both legs negative with non-negative sum: below range
    assign v = en &  x[MSB] &  y[MSB] & ~sum[MSB];
    assign r = {sum[MSB] ^ c, sum[MSB-1:0]};
endmodule

// File: rtl/flag_alu_bits.sv
module flag_alu_bits #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] rol_b,
    output logic [W-1:0] ror_a,
    output logic [W-1:0] or_ab,
    output logic [W-1:0] and_ab,
    output logic [W-1:0] xor_ab,
    output logic [W-1:0] max_ab
);
    assign rol_b  = {b[W-2:0], b[W-1]};
    assign ror_a  = {a[0], a[W-1:1]};
    assign or_ab  = a | b;
    assign and_ab = a & b;
    assign xor_ab = a ^ b;
    assign max_ab = (a >= b) ? a : b;
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [OP_W-1:0]   s_i,
    output logic [W-1:0]      r_o,
    output logic              c_o,
    output logic              v_o
);
    logic [W-1:0]    a_q, b_q;
    logic [OP_W-1:0] s_q;
    logic [OP_N-1:0] hot;
    route_t          rt;
    logic            arith_en;
    logic [W-1:0]    ar_r;
    logic            ar_c, ar_v;
    logic [W-1:0]    rol_b, ror_a, or_ab, and_ab, xor_ab, max_ab;
    logic [W-1:0]    sel_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
            s_q <= '0;
        end else begin
            a_q <= a_i;
            b_q <= b_i;
            s_q <= s_i;
        end
    end

    flag_alu_decode u_dec (.op(s_q), .hot(hot));

    assign rt       = route_for(hot);
    assign arith_en = is_arith(hot);

    flag_alu_arith #(.W(W)) u_arith (
        .a(a_q), .b(b_q), .rt(rt), .en(arith_en),
        .r(ar_r), .c(ar_c), .v(ar_v)
    );

    flag_alu_bits #(.W(W)) u_bits (
        .a(a_q), .b(b_q),
        .rol_b(rol_b), .ror_a(ror_a), .or_ab(or_ab),
        .and_ab(and_ab), .xor_ab(xor_ab), .max_ab(max_ab)
    );

    // one-hot AND-OR output selector
    assign sel_r = ({W{arith_en}}        & ar_r)
                 | ({W{hot[OP_PASS_A]}}  & a_q)
                 | ({W{hot[OP_PASS_B]}}  & b_q)
                 | ({W{hot[OP_ROL_B]}}   & rol_b)
                 | ({W{hot[OP_ROR_A]}}   & ror_a)
                 | ({W{hot[OP_OR]}}      & or_ab)
                 | ({W{hot[OP_AND]}}     & and_ab)
                 | ({W{hot[OP_XOR]}}     & xor_ab)
                 | ({W{hot[OP_MAX]}}     & max_ab);

    always_ff @(negedge clk) begin
        if (rst) begin
            r_o <= '0;
            c_o <= 1'b0;
            v_o <= 1'b0;
        end else begin
            r_o <= sel_r;
            c_o <= ar_c;
            v_o <= ar_v;
        end
    end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
    import flag_alu_pkg::*;
#(
    parameter int W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [W-1:0]    a_i,
    input logic [OP_W-1:0] s_i,
    input logic [W-1:0]    a_q,
    input logic [W-1:0]    b_q,
    input logic [OP_W-1:0] s_q,
    input logic [W-1:0]    r_o,
    input logic            c_o,
    input logic            v_o
);
    localparam logic [W-1:0] TOP_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] BOT_NEG = {1'b1, {(W-1){1'b0}}};

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (s_q == $past(s_i)) && (a_q == $past(a_i)));

    // R4
    xor_result_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q == OP_XOR) |-> (r_o == (a_q ^ b_q)));

    // R5
    max_result_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q == OP_MAX) |-> ((r_o == a_q) || (r_o == b_q)) && (r_o >= a_q) && (r_o >= b_q));

    // R7
    inc_top_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q == OP_INC_A && a_q == TOP_POS) |-> (c_o && !v_o && r_o == '0));

    // R8
    dec_bot_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q == OP_DEC_A && a_q == BOT_NEG) |-> (v_o && !c_o));

    // R9
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(c_o && v_o));

    // R9
    flag_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (c_o || v_o) |-> !r_o[W-1]);

    // R9
    logic_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q == OP_PASS_A || s_q == OP_ROL_B || s_q == OP_PASS_B || s_q == OP_OR ||
         s_q == OP_ROR_A || s_q == OP_AND || s_q == OP_XOR || s_q == OP_MAX)
        |-> (!c_o && !v_o));
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .a_i(a_i), .s_i(s_i),
    .a_q(a_q), .b_q(b_q), .s_q(s_q),
    .r_o(r_o), .c_o(c_o), .v_o(v_o)
);

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a_i = '0;
    logic [3:0] b_i = '0;
    logic [3:0] s_i = '0;
    logic [3:0] r_o;
    logic       c_o, v_o;

    int total = 0;
    int fails = 0;
    logic [5:0] prev_exp;

    flag_alu dut (
        .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .s_i(s_i),
        .r_o(r_o), .c_o(c_o), .v_o(v_o)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic int sval(input logic [3:0] x);
        return x[3] ? int'(x) - 16 : int'(x);
    endfunction

    // returns {r, c, v}
    function automatic logic [5:0] model(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b);
        int ex;
        logic ar, cf, vf;
        logic [3:0] r, t;
        ar = 1'b1; ex = 0; r = '0;
        case (op)
            4'h2: ex = sval(a) - sval(b);
            4'h4: ex = sval(a) + 1;
            4'h5: ex = sval(a) - 1;
            4'h6: ex = sval(b) + 1;
            4'h7: ex = sval(a) + sval(b);
            4'h8: ex = sval(b) - 1;
            4'hE: ex = -sval(b);
            4'hF: ex = -sval(a);
            default: ar = 1'b0;
        endcase
        if (ar) begin
            cf = (ex > 7);
            vf = (ex < -8);
            t  = 4'(ex);
            r  = {t[3] ^ cf, t[2:0]};
        end else begin
            cf = 1'b0; vf = 1'b0;
            case (op)
                4'h0: r = a;
                4'h1: r = {b[2:0], b[3]};
                4'h3: r = b;
                4'h9: r = a | b;
                4'hA: r = {a[0], a[3:1]};
                4'hB: r = a & b;
                4'hC: r = a ^ b;
                default: r = (a > b) ? a : b;
            endcase
        end
        return {r, cf, vf};
    endfunction

    function automatic string tag_for(input logic [3:0] op);
        case (op)
            4'h0, 4'h1, 4'h3, 4'hA: return "R3 R9";
            4'h9, 4'hB, 4'hC:       return "R4 R9";
            4'hD:                   return "R5 R9";
            default:                return "R6 R7 R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [5:0] exp, input logic [3:0] op,
                         input logic [3:0] a, input logic [3:0] b);
        total++;
        if ({r_o, c_o, v_o} !== exp) begin
            fails++;
            $display("FAIL %s op=%h a=%b b=%b got r=%b c=%b v=%b exp r=%b c=%b v=%b",
                     tag, op, a, b, r_o, c_o, v_o, exp[5:2], exp[1], exp[0]);
        end
    endtask

    // called just after a falling edge
    task automatic apply(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b,
                         input logic [5:0] exp, input string tag);
        s_i = op; a_i = a; b_i = b;
        @(posedge clk); #1;
        check("R2 hold", prev_exp, op, a, b);
        s_i = ~op; a_i = ~a; b_i = ~b;
        @(negedge clk); #1;
        check(tag, exp, op, a, b);
        prev_exp = exp;
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // R1: reset state
        a_i = 4'hF; b_i = 4'hF; s_i = 4'h7;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset", 6'b0, 4'h0, 4'h0, 4'h0);
        rst = 1'b0;
        prev_exp = '0;

        // directed vectors with literal expectations
        apply(4'h2, 4'b1001, 4'b0110, {4'b0011, 1'b0, 1'b1}, "R6 R8 sub");
        apply(4'h1, 4'b1001, 4'b0110, {4'b1100, 1'b0, 1'b0}, "R3 rol");
        apply(4'hA, 4'b1001, 4'b0110, {4'b1100, 1'b0, 1'b0}, "R3 ror");
        apply(4'hD, 4'b1001, 4'b0110, {4'b1001, 1'b0, 1'b0}, "R5 max");
        apply(4'hF, 4'b1001, 4'b0110, {4'b0111, 1'b0, 1'b0}, "R6 neg");
        apply(4'h4, 4'b0111, 4'b0101, {4'b0000, 1'b1, 1'b0}, "R7 inc");
        apply(4'h7, 4'b0111, 4'b0101, {4'b0100, 1'b1, 1'b0}, "R7 add");
        apply(4'hA, 4'b0111, 4'b0101, {4'b1011, 1'b0, 1'b0}, "R3 ror");
        apply(4'hE, 4'b0111, 4'b0101, {4'b1011, 1'b0, 1'b0}, "R6 neg");
        apply(4'hE, 4'b0000, 4'b1000, {4'b0000, 1'b1, 1'b0}, "R7 neg min");
        apply(4'h8, 4'b0000, 4'b1000, {4'b0111, 1'b0, 1'b1}, "R8 dec min");
        apply(4'hC, 4'b1100, 4'b1010, {4'b0110, 1'b0, 1'b0}, "R4 xor");

        // exhaustive sweep against the arithmetic model
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    apply(4'(op), 4'(a), 4'(b), model(4'(op), 4'(a), 4'(b)), tag_for(4'(op)));

        // R1: mid-run reset clears the outputs
        s_i = 4'h7; a_i = 4'b0111; b_i = 4'b0111;
        rst = 1'b1;
        @(negedge clk); #1;
        @(negedge clk); #1;
        check("R1 mid reset", 6'b0, 4'h7, 4'b0111, 4'b0111);
        rst = 1'b0;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule